// File: doc/BRIEF.md
# Shadowed RAM Store/Recall Controller

This block holds a 256-word by 4-bit working RAM and a shadow array of the same shape that stands in for nonvolatile cells. A host reads and writes the working RAM through a simple select/write-enable port. Two active-low request inputs move the whole array in one direction or the other: a store copies the RAM into the shadow array, and a recall copies the shadow array back into the RAM. Both transfers walk the array one word per step over many clock cycles.

The controller arbitrates the transfers against the host port. A transfer always wins, and recall outranks store. A power-good input models supply sensing: while it is low nothing happens, and each time it rises a recall runs on its own. Store requests pass through a minimum-width filter so that short glitches cannot start a store. A store takes far longer than a recall, and each duration is set by its own per-word cycle-count parameter.

Top module: `nvsram_ctrl`

## Requirements
- R1: With pwr_good high, no transfer running or starting, cs_n low and we_n low, the word at addr is replaced by wdata at the clock edge; the RAM holds 256 words of 4 bits selected by the 8-bit addr.
- R2: With pwr_good high, no transfer running or starting, cs_n low and we_n high, rdata shows the word at addr and rdata_oe is 1 in the cycle after the request.
- R3: rdata_oe is 0 (and rdata is 0) in the cycle after any cycle with cs_n high, we_n low, pwr_good low, a transfer running or a transfer starting.
- R4: A store starts when store_n has been sampled low on STORE_MIN_LOW consecutive edges; busy rises after that edge and stays high for exactly 256*STORE_STEP cycles, after which the shadow array equals the RAM.
- R5: A store_n low period shorter than STORE_MIN_LOW sampled edges does not start a store.
- R6: While a store runs, host writes and recall requests have no effect, and a store_n held low past the end of the store does not start another.
- R7: A falling edge of recall_n while idle starts a recall; busy stays high for exactly 256*RECALL_STEP cycles, after which the RAM equals the shadow array.
- R8: While recall_n is low, a store request is ignored; when both requests arrive together the recall runs.
- R9: A host access presented in the cycle in which a transfer starts is not performed.
- R10: When pwr_good rises (including the first rise after reset) a recall starts with no request.
- R11: While pwr_good is low, a running transfer is abandoned at once (busy low after the next edge) and store, recall and host requests have no effect.
- R12: A transfer copies word 0 first and proceeds in ascending address order, one word per step, ending with word 255; an abandoned store leaves the words below its stopping point copied and the rest untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears both arrays |
| pwr_good | input | 1 | Supply-good indication, high when operation is allowed |
| cs_n | input | 1 | Active-low host select |
| we_n | input | 1 | Active-low host write enable |
| addr | input | 8 | Host word address |
| wdata | input | 4 | Host write data |
| store_n | input | 1 | Active-low store request |
| recall_n | input | 1 | Active-low recall request |
| rdata | output | 4 | Host read data, zero when not enabled |
| rdata_oe | output | 1 | Read data valid / output enable |
| busy | output | 1 | High while a store or recall transfer runs |

## Verification
A wrong transfer pointer or step counter shows first on busy, whose length and fall are fixed by the step parameters, and later as wrong words when the RAM is read back after a recall. A broken arbitration rule shows within one cycle as an unexpected rdata_oe or busy level, or as a stale or corrupted word on the next read of the touched address. A faulty store filter shows as busy rising one cycle early, late, or not at all after a short pulse. Abandoning a store half-way through and recalling it exposes the copy order through which addresses changed.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_STORE  = 2'd1,
        XF_RECALL = 2'd2
    } xfer_mode_e;

endpackage

// File: rtl/nvs_store_filter.sv
module nvs_store_filter #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_n,
    output logic fire_o
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } flt_state_t;

    flt_state_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        fire_o = 1'b0;
        if (store_n) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != CNT_W'(MIN_LOW)) begin
            s_d.cnt = s_q.cnt + 1'b1;
            fire_o  = (s_q.cnt == CNT_W'(MIN_LOW - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o); // R6

endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq
    import nvs_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STORE_STEP  = 16,
    parameter int RECALL_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              recall_n,
    input  logic              store_fire,
    output logic              busy_o,
    output logic              start_o,
    output logic              store_we_o,
    output logic              recall_we_o,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int MAX_STEP = (STORE_STEP > RECALL_STEP) ? STORE_STEP : RECALL_STEP;
    localparam int TICK_W   = $clog2(MAX_STEP + 1);

    typedef struct packed {
        xfer_mode_e        mode;
        logic [ADDR_W-1:0] ptr;
        logic [TICK_W-1:0] tick;
        logic              pg;
        logic              rcl;
    } seq_state_t;

    seq_state_t s_q, s_d;
    logic       last_tick;

    always_comb begin
        s_d         = s_q;
        start_o     = 1'b0;
        store_we_o  = 1'b0;
        recall_we_o = 1'b0;
        s_d.pg      = pwr_good;
        s_d.rcl     = recall_n;
        last_tick   = (s_q.mode == XF_STORE) ? (s_q.tick == TICK_W'(STORE_STEP - 1))
                                             : (s_q.tick == TICK_W'(RECALL_STEP - 1));
        if (!pwr_good) begin
            s_d.mode = XF_IDLE;
            s_d.ptr  = '0;
            s_d.tick = '0;
        end else if (!s_q.pg) begin
            start_o  = 1'b1;
            s_d.mode = XF_RECALL;
            s_d.ptr  = '0;
            s_d.tick = '0;
        end else if (s_q.mode == XF_IDLE) begin
            if (!recall_n && s_q.rcl) begin
                start_o  = 1'b1;
                s_d.mode = XF_RECALL;
                s_d.ptr  = '0;
                s_d.tick = '0;
            end else if (store_fire && recall_n) begin
                start_o  = 1'b1;
                s_d.mode = XF_STORE;
                s_d.ptr  = '0;
                s_d.tick = '0;
            end
        end else if (last_tick) begin
            store_we_o  = (s_q.mode == XF_STORE);
            recall_we_o = (s_q.mode == XF_RECALL);
            s_d.tick    = '0;
            s_d.ptr     = s_q.ptr + 1'b1;
            if (s_q.ptr == ADDR_W'(DEPTH - 1)) s_d.mode = XF_IDLE;
        end else begin
            s_d.tick = s_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= XF_IDLE;
            s_q.rcl  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.mode != XF_IDLE);
    assign ptr_o  = s_q.ptr;

    AST_PG_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !busy_o); // R11
    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (ptr_o == '0)); // R12
    AST_END_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(ptr_o) == ADDR_W'(DEPTH - 1) || !$past(pwr_good))); // R12
    AST_STORE_NO_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == XF_STORE) |=> (s_q.mode != XF_RECALL)); // R6

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              store_we,
    input  logic              recall_we,
    input  logic [ADDR_W-1:0] xfer_addr,
    output logic [DATA_W-1:0] host_rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram_q [DEPTH];
    logic [DATA_W-1:0] ram_d [DEPTH];
    logic [DATA_W-1:0] shd_q [DEPTH];
    logic [DATA_W-1:0] shd_d [DEPTH];

    always_comb begin
        ram_d = ram_q;
        shd_d = shd_q;
        if (host_we)   ram_d[host_addr] = host_wdata;
        if (store_we)  shd_d[xfer_addr] = ram_q[xfer_addr];
        if (recall_we) ram_d[xfer_addr] = shd_q[xfer_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ram_q[i] <= '0;
                shd_q[i] <= '0;
            end
        end else begin
            ram_q <= ram_d;
            shd_q <= shd_d;
        end
    end

    assign host_rword = ram_q[host_addr];

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_we, store_we, recall_we})); // R9

endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 4,
    parameter int STORE_STEP    = 16,
    parameter int RECALL_STEP   = 2,
    parameter int STORE_MIN_LOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              store_n,
    input  logic              recall_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              busy
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              oe;
    } rd_state_t;

    rd_state_t         r_q, r_d;
    logic              store_fire, start, store_we, recall_we;
    logic              host_ok, host_we;
    logic [ADDR_W-1:0] xfer_ptr;
    logic [DATA_W-1:0] rword;

    nvs_store_filter #(.MIN_LOW(STORE_MIN_LOW)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_n (store_n),
        .fire_o  (store_fire)
    );

    nvs_xfer_seq #(
        .ADDR_W      (ADDR_W),
        .STORE_STEP  (STORE_STEP),
        .RECALL_STEP (RECALL_STEP)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .recall_n    (recall_n),
        .store_fire  (store_fire),
        .busy_o      (busy),
        .start_o     (start),
        .store_we_o  (store_we),
        .recall_we_o (recall_we),
        .ptr_o       (xfer_ptr)
    );

    nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (addr),
        .host_wdata (wdata),
        .store_we   (store_we),
        .recall_we  (recall_we),
        .xfer_addr  (xfer_ptr),
        .host_rword (rword)
    );

    always_comb begin
        host_ok  = pwr_good && !busy && !start && !cs_n;
        host_we  = host_ok && !we_n;
        r_d.oe   = host_ok && we_n;
        r_d.rdata = r_d.oe ? rword : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata    = r_q.rdata;
    assign rdata_oe = r_q.oe;

    AST_OE_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rdata_oe); // R3
    AST_NO_OE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !rdata_oe); // R3

endmodule

// File: tb/tb_nvsram_ctrl.sv
module tb_nvsram_ctrl;
    localparam int SST = 16;
    localparam int RST = 2;
    localparam int MINL = 4;

    logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0;
    logic cs_n = 1'b1, we_n = 1'b1, store_n = 1'b1, recall_n = 1'b1;
    logic [7:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic rdata_oe, busy;

    int checks = 0, errors = 0, busy_cnt = 0;
    bit done = 0;

    nvsram_ctrl #(.STORE_STEP(SST), .RECALL_STEP(RST), .STORE_MIN_LOW(MINL)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .store_n(store_n), .recall_n(recall_n),
        .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy));

    always #2.5 clk = ~clk;

    // behavioural reference model
    int m_ram[256], m_sh[256];
    int m_mode = 0, m_ptr = 0, m_tick = 0, m_cnt = 0;
    int m_oe = 0, m_rd = 0, m_busy = 0;
    bit m_pgp = 0, m_rcp = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_ram[i]) begin m_ram[i] = 0; m_sh[i] = 0; end
            m_mode = 0; m_ptr = 0; m_tick = 0; m_cnt = 0;
            m_oe = 0; m_rd = 0; m_busy = 0; m_pgp = 0; m_rcp = 1;
        end else begin
            bit fire, st, ok;
            int pmode, step;
            fire = !store_n && (m_cnt == MINL - 1);
            if (store_n) m_cnt = 0; else if (m_cnt < MINL) m_cnt++;
            pmode = m_mode;
            st = 0;
            if (!pwr_good) begin m_mode = 0; m_ptr = 0; m_tick = 0; end
            else if (!m_pgp) begin m_mode = 2; m_ptr = 0; m_tick = 0; st = 1; end
            else if (m_mode == 0) begin
                if (!recall_n && m_rcp) begin m_mode = 2; m_ptr = 0; m_tick = 0; st = 1; end
                else if (fire && recall_n) begin m_mode = 1; m_ptr = 0; m_tick = 0; st = 1; end
            end else begin
                step = (m_mode == 1) ? SST : RST;
                if (m_tick == step - 1) begin
                    if (m_mode == 1) m_sh[m_ptr] = m_ram[m_ptr];
                    else m_ram[m_ptr] = m_sh[m_ptr];
                    m_tick = 0;
                    if (m_ptr == 255) m_mode = 0;
                    m_ptr = (m_ptr + 1) % 256;
                end else m_tick++;
            end
            ok = pwr_good && pmode == 0 && !st && !cs_n;
            m_oe = (ok && we_n) ? 1 : 0;
            m_rd = m_oe ? m_ram[addr] : 0;
            if (ok && !we_n) m_ram[addr] = int'(wdata);
            m_pgp = pwr_good; m_rcp = recall_n;
            m_busy = (m_mode != 0) ? 1 : 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("R4 R7 busy vs model", int'(busy), m_busy);
        chk("R3 oe vs model", int'(rdata_oe), m_oe);
        chk("R2 rdata vs model", int'(rdata), m_rd);
        if (busy) busy_cnt++;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(int a, int d);
        cs_n = 0; we_n = 0; addr = 8'(a); wdata = 4'(d);
        tick();
        cs_n = 1; we_n = 1;
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        cs_n = 0; we_n = 1; addr = 8'(a);
        tick();
        cs_n = 1;
        chk(tag, int'(rdata_oe), 1);
        chk(tag, int'(rdata), exp);
    endtask

    task automatic run_out();
        while (busy) tick();
    endtask

    function automatic int pat(int i);
        return (i * 7 + 3) % 16;
    endfunction

    initial begin
        ticks(3);
        chk("R3 reset oe", int'(rdata_oe), 0);
        chk("R11 reset busy", int'(busy), 0);
        rst_n = 1;
        ticks(2);
        // R11: requests while power is low
        recall_n = 0; store_n = 0; ticks(6); recall_n = 1; store_n = 1;
        cs_n = 0; we_n = 1; tick(); cs_n = 1;
        chk("R11 pg low busy", int'(busy), 0);
        chk("R11 pg low oe", int'(rdata_oe), 0);
        // R10: auto recall
        pwr_good = 1; busy_cnt = 0;
        tick();
        chk("R10 auto recall start", int'(busy), 1);
        run_out();
        chk("R7 recall length", busy_cnt, 256 * RST);
        rd_chk("R7 ram cleared by recall", 17, 0);
        // R1 R2 fill and read
        for (int i = 0; i < 256; i++) wr(i, pat(i));
        rd_chk("R1 R2 addr0", 0, pat(0));
        rd_chk("R1 R2 addr255", 255, pat(255));
        rd_chk("R1 R2 addr77", 77, pat(77));
        // R3 deselected / write cycle
        cs_n = 1; we_n = 1; tick();
        chk("R3 cs high oe", int'(rdata_oe), 0);
        cs_n = 0; we_n = 0; addr = 8'd3; wdata = 4'(pat(3)); tick(); cs_n = 1; we_n = 1;
        chk("R3 write oe", int'(rdata_oe), 0);
        // R5 short store pulse
        busy_cnt = 0;
        store_n = 0; ticks(MINL - 1); store_n = 1; ticks(8);
        chk("R5 short pulse no store", busy_cnt, 0);
        // R4 store
        store_n = 0; ticks(MINL - 1);
        chk("R4 not yet", int'(busy), 0);
        busy_cnt = 0; tick();
        chk("R4 store start", int'(busy), 1);
        wr(5, 4'hF ^ pat(5));           // R6 ignored
        recall_n = 0; ticks(2); recall_n = 1; // R6 ignored
        cs_n = 0; we_n = 1; tick(); cs_n = 1;
        chk("R3 oe during store", int'(rdata_oe), 0);
        run_out();
        chk("R4 store length", busy_cnt, 256 * SST);
        busy_cnt = 0; ticks(10);
        chk("R6 held store no restart", busy_cnt, 0);
        store_n = 1;
        rd_chk("R6 write during store ignored", 5, pat(5));
        // R7 recall restores stored image
        wr(0, 4'hF ^ pat(0)); wr(100, 4'hF ^ pat(100)); wr(255, 4'hF ^ pat(255));
        rd_chk("R1 overwrite", 100, 15 ^ pat(100));
        recall_n = 0; busy_cnt = 0; tick();
        chk("R7 recall start", int'(busy), 1);
        run_out();
        chk("R7 recall length", busy_cnt, 256 * RST);
        // R8 recall held low blocks store
        busy_cnt = 0; store_n = 0; ticks(MINL + 4); store_n = 1;
        chk("R8 store blocked by recall low", busy_cnt, 0);
        recall_n = 1; tick();
        rd_chk("R7 restored 0", 0, pat(0));
        rd_chk("R7 restored 100", 100, pat(100));
        rd_chk("R7 restored 255", 255, pat(255));
        // R8 simultaneous requests
        store_n = 0; recall_n = 0; tick();
        chk("R8 recall wins busy", int'(busy), 1);
        run_out(); store_n = 1; recall_n = 1; tick();
        rd_chk("R8 no store ran", 0, pat(0));
        // R9 write in start cycle dropped
        store_n = 0; ticks(MINL - 1);
        cs_n = 0; we_n = 0; addr = 8'd9; wdata = 4'(15 ^ pat(9)); tick(); cs_n = 1; we_n = 1;
        chk("R9 store started", int'(busy), 1);
        run_out(); store_n = 1; tick();
        rd_chk("R9 start-cycle write dropped", 9, pat(9));
        // R11 R12 abort mid store
        wr(0, 4'hA); wr(255, 4'h5);
        store_n = 0; ticks(MINL); store_n = 1;
        ticks(20 * SST);
        pwr_good = 0; tick();
        chk("R11 abort busy", int'(busy), 0);
        store_n = 0; recall_n = 0; ticks(6); store_n = 1; recall_n = 1;
        wr(0, 4'h1);
        chk("R11 still idle", int'(busy), 0);
        pwr_good = 1; busy_cnt = 0; tick();
        chk("R10 auto recall again", int'(busy), 1);
        run_out();
        rd_chk("R12 low word stored", 0, 10);
        rd_chk("R12 high word not stored", 255, pat(255));
        ticks(3);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule